// File: doc/BRIEF.md
# Oversampled UART Receiver with Packing

This block is the receive half of a serial port that runs on the peripheral clock. A programmable divisor produces a sampling tick at sixteen times the baud rate. The asynchronous line first passes through a two-flop synchronizer. The receiver then confirms a start bit at its midpoint and samples each following bit sixteen ticks later, so every bit is read near its centre. Data arrives least significant bit first, in 8- or 9-bit words, with an optional parity bit and exactly one stop bit.

Bits collect in a shift register. Once the stop bit has been sampled, the word and its status (framing and parity errors) are written into a 32-bit receive buffer. A data-ready flag rises one clock after that write, and a read strobe clears it.

In packing mode two consecutive words share one buffer word. The first word lands at bits 8:0 and the second at bits 24:16. Every other bit is zero, and data-ready waits for the second word. If a word is stored while data-ready is still set, the block flags an overrun.

Top module: `uart_rx_pack`

## Requirements
- R1: The sampling tick fires once every `divisor` clocks, and a divisor of 0 behaves as 1. One bit period is 16 ticks, so a bit lasts 16×max(divisor,1) clocks.
- R2: Data bits are received least significant bit first. With `nine_bit`=1 the 9 data bits appear in `rbuf[8:0]`. With `nine_bit`=0 the 8 data bits appear in `rbuf[7:0]` and `rbuf[8]`=0. Outside packing mode `rbuf[31:9]` is zero.
- R3: The line passes through a two-flop synchronizer. A low sample on a tick while idle starts a candidate start bit. The start is accepted only if the line is still low on the 8th tick counted from that sample. Otherwise the candidate is dropped and no word is produced.
- R4: Exactly one stop bit is sampled, at its middle. If it reads low, `frame_err`=1 is stored with the word; if it reads high, `frame_err`=0.
- R5: With `par_en`=1 a parity bit follows the data. `par_odd`=0 selects even parity (data ones plus the parity bit give an even count) and `par_odd`=1 selects odd parity. A mismatch stores `parity_err`=1. With `par_en`=0, `parity_err`=0.
- R6: Sampling re-aligns on every start bit. Back-to-back frames whose bit rate is off by ±2% are decoded correctly.
- R7: `rbuf` does not change before the stop bit is sampled. The buffer is written one clock after that sample, and `data_ready` rises one clock after the write.
- R8: `rd_strobe` clears `data_ready` on the next clock. A ready that is due to be set in that same clock takes precedence over the read.
- R9: A word stored while `data_ready`=1 (and no read in that clock) sets `overrun` and overwrites the buffer. `rd_strobe` clears `overrun`.
- R10: With `pack_en`=1 the first word goes to bits 8:0 and the second to bits 24:16. All other bits are zero. `data_ready` is set only after the second word, and the error flags are the OR over the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_async | input | 1 | Serial receive line, asynchronous, idle high |
| divisor | input | DIV_W | Clock divisor for the 16× tick (0 acts as 1) |
| nine_bit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| pack_en | input | 1 | Pack two words per buffer word |
| rd_strobe | input | 1 | Buffer read, clears ready and overrun |
| rbuf | output | 32 | Receive buffer |
| data_ready | output | 1 | Buffer holds an unread word |
| frame_err | output | 1 | Stop bit of stored word(s) was low |
| parity_err | output | 1 | Parity of stored word(s) mismatched |
| overrun | output | 1 | A word was stored over an unread one |

## Verification
Several properties are checked on every cycle:
- the tick spacing against the divisor;
- the two-cycle synchronizer latency;
- the ordering of buffer write, pending flag and `data_ready`;
- that a read clears the flag while a pending set wins;
- overrun on a store over unread data;
- the zero bits between the packed lanes.

Only the bench scenarios can show the decoded data, the parity and framing results, glitch rejection, tolerance to ±2% rate error, the packed pair layout and the moment `data_ready` appears in packing mode. These depend on whole serial frames driven in real time.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_phase_e;

    typedef struct packed {
        logic [8:0] data;
        logic       frame_err;
        logic       parity_err;
    } rx_word_t;

    localparam int unsigned TICKS_PER_BIT = 16;
    localparam int unsigned MID_TICK      = TICKS_PER_BIT / 2 - 1;
    localparam int unsigned BUF_W         = 32;
    localparam int unsigned HI_LANE       = 16;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: '1};
        else        st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (divisor == '0) ? DIV_W'(1) : divisor;
        st_d = st_q;
        if (st_q.cnt >= limit - DIV_W'(1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + DIV_W'(1);
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rx,
    input  logic     nine_bit,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     word_valid,
    output rx_word_t word
);
    typedef struct packed {
        rx_phase_e  phase;
        logic [3:0] sub;
        logic [3:0] bitn;
        logic [8:0] shreg;
        logic       par_acc;
        logic       perr;
        logic       valid;
        rx_word_t   word;
    } frame_st_t;

    frame_st_t  st_d, st_q;
    logic [3:0] last_bit;
    logic       sample_now;

    always_comb begin
        last_bit   = nine_bit ? 4'd8 : 4'd7;
        sample_now = tick && (st_q.sub == 4'(TICKS_PER_BIT - 1));
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (tick && (st_q.phase == RX_DATA || st_q.phase == RX_PARITY || st_q.phase == RX_STOP))
            st_d.sub = sample_now ? 4'd0 : st_q.sub + 4'd1;
        case (st_q.phase)
            RX_IDLE: begin
                if (tick && !rx) begin
                    st_d.phase = RX_START;
                    st_d.sub   = 4'd1;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (st_q.sub == 4'(MID_TICK)) begin
                        if (!rx) begin
                            st_d.phase   = RX_DATA;
                            st_d.sub     = 4'd0;
                            st_d.bitn    = 4'd0;
                            st_d.shreg   = '0;
                            st_d.par_acc = 1'b0;
                            st_d.perr    = 1'b0;
                        end else begin
                            st_d.phase = RX_IDLE;
                        end
                    end else begin
                        st_d.sub = st_q.sub + 4'd1;
                    end
                end
            end
            RX_DATA: begin
                if (sample_now) begin
                    st_d.shreg   = {rx, st_q.shreg[8:1]};
                    st_d.par_acc = st_q.par_acc ^ rx;
                    if (st_q.bitn == last_bit) begin
                        st_d.bitn  = 4'd0;
                        st_d.phase = par_en ? RX_PARITY : RX_STOP;
                    end else begin
                        st_d.bitn = st_q.bitn + 4'd1;
                    end
                end
            end
            RX_PARITY: begin
                if (sample_now) begin
                    st_d.perr  = (rx != (st_q.par_acc ^ par_odd));
                    st_d.phase = RX_STOP;
                end
            end
            RX_STOP: begin
                if (sample_now) begin
                    st_d.valid           = 1'b1;
                    st_d.word.data       = nine_bit ? st_q.shreg : {1'b0, st_q.shreg[8:1]};
                    st_d.word.frame_err  = !rx;
                    st_d.word.parity_err = par_en && st_q.perr;
                    st_d.phase           = RX_IDLE;
                end
            end
            default: st_d.phase = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: RX_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign word_valid = st_q.valid;
    assign word       = st_q.word;
endmodule

// File: rtl/uart_rx_packbuf.sv
module uart_rx_packbuf
    import uart_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_valid,
    input  rx_word_t         word,
    input  logic             pack_en,
    input  logic             rd_strobe,
    output logic [BUF_W-1:0] rbuf,
    output logic             data_ready,
    output logic             frame_err,
    output logic             parity_err,
    output logic             overrun,
    output logic             ready_pend
);
    localparam int unsigned LO_PAD = BUF_W - 9;
    localparam int unsigned HI_PAD = BUF_W - HI_LANE - 9;

    typedef struct packed {
        logic [BUF_W-1:0] rbuf;
        logic             ready;
        logic             pend;
        logic             half;
        logic             ferr;
        logic             perr;
        logic             ovr;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        if (rd_strobe) begin
            st_d.ready = 1'b0;
            st_d.ovr   = 1'b0;
        end
        if (st_q.pend) st_d.ready = 1'b1;
        if (!pack_en)  st_d.half  = 1'b0;
        if (word_valid) begin
            if (st_q.ready && !rd_strobe) st_d.ovr = 1'b1;
            if (!pack_en || !st_q.half) begin
                st_d.rbuf = {{LO_PAD{1'b0}}, word.data};
                st_d.ferr = word.frame_err;
                st_d.perr = word.parity_err;
                st_d.half = pack_en;
                st_d.pend = !pack_en;
            end else begin
                st_d.rbuf = {{HI_PAD{1'b0}}, word.data, st_q.rbuf[HI_LANE-1:0]};
                st_d.ferr = st_q.ferr | word.frame_err;
                st_d.perr = st_q.perr | word.parity_err;
                st_d.half = 1'b0;
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rbuf       = st_q.rbuf;
    assign data_ready = st_q.ready;
    assign frame_err  = st_q.ferr;
    assign parity_err = st_q.perr;
    assign overrun    = st_q.ovr;
    assign ready_pend = st_q.pend;
endmodule

// File: rtl/uart_rx_pack.sv
module uart_rx_pack
    import uart_rx_pkg::*;
#(
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_async,
    input  logic [DIV_W-1:0] divisor,
    input  logic             nine_bit,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             pack_en,
    input  logic             rd_strobe,
    output logic [31:0]      rbuf,
    output logic             data_ready,
    output logic             frame_err,
    output logic             parity_err,
    output logic             overrun
);
    logic     rx_s;
    logic     tick;
    logic     word_valid;
    rx_word_t word;
    logic     ready_pend;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd_async), .dout(rx_s)
    );

    uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    uart_rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
        .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
        .word_valid(word_valid), .word(word)
    );

    uart_rx_packbuf u_buf (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word),
        .pack_en(pack_en), .rd_strobe(rd_strobe), .rbuf(rbuf),
        .data_ready(data_ready), .frame_err(frame_err),
        .parity_err(parity_err), .overrun(overrun), .ready_pend(ready_pend)
    );
endmodule

// File: rtl/uart_rx_pack_chk.sv
module uart_rx_pack_chk #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rxd_async,
    input logic             sync_rx,
    input logic             tick,
    input logic [DIV_W-1:0] divisor,
    input logic             store,
    input logic             pend,
    input logic             rd_strobe,
    input logic             data_ready,
    input logic             overrun,
    input logic [31:0]      rbuf
);
    logic [DIV_W-1:0] gap_q, div_q, lim;
    logic             armed_q;
    logic [1:0]       cyc_q;

    assign lim = (divisor == '0) ? DIV_W'(1) : divisor;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            div_q   <= '0;
            armed_q <= 1'b0;
            cyc_q   <= '0;
        end else begin
            div_q <= divisor;
            if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
            if (divisor != div_q) begin
                armed_q <= 1'b0;
                gap_q   <= '0;
            end else if (tick) begin
                armed_q <= 1'b1;
                gap_q   <= '0;
            end else begin
                gap_q <= gap_q + DIV_W'(1);
            end
        end
    end

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        tick && armed_q && (divisor == div_q) |-> gap_q == lim - DIV_W'(1)); // R1
    AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> sync_rx == $past(rxd_async, 2)); // R3
    AST_PEND_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> $past(store)); // R7
    AST_READY_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(pend)); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !pend |=> !data_ready); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> data_ready); // R8
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        store && data_ready && !rd_strobe |=> overrun); // R9
    AST_ZERO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        rbuf[31:25] == '0 && rbuf[15:9] == '0); // R10
endmodule

bind uart_rx_pack uart_rx_pack_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rxd_async(rxd_async), .sync_rx(rx_s),
    .tick(tick), .divisor(divisor), .store(word_valid), .pend(ready_pend),
    .rd_strobe(rd_strobe), .data_ready(data_ready), .overrun(overrun),
    .rbuf(rbuf)
);

// File: tb/uart_rx_pack_test.sv
`timescale 1ns/1ps
module uart_rx_pack_test;
    localparam int unsigned DIV_W = 16;
    localparam real CLK_NS = 5.0;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rxd = 1'b1;
    logic [DIV_W-1:0] divisor = 16'd4;
    logic             nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic             pack_en = 1'b0, rd_strobe = 1'b0;
    logic [31:0]      rbuf;
    logic             data_ready, frame_err, parity_err, overrun;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  mon_en   = 1'b1;
    bit  done     = 1'b0;

    typedef struct packed {
        logic [31:0] word;
        logic        fe;
        logic        pe;
    } exp_t;
    exp_t  sb_q[$];
    string tag_q[$];

    always #(CLK_NS / 2.0) clk = ~clk;

    uart_rx_pack #(.DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .rxd_async(rxd), .divisor(divisor),
        .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
        .pack_en(pack_en), .rd_strobe(rd_strobe), .rbuf(rbuf),
        .data_ready(data_ready), .frame_err(frame_err),
        .parity_err(parity_err), .overrun(overrun)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_word(input logic [31:0] w, input logic fe, input logic pe,
                               input string tag);
        sb_q.push_back('{word: w, fe: fe, pe: pe});
        tag_q.push_back(tag);
    endtask

    function automatic real bit_ns(input real factor);
        int unsigned d;
        d = (divisor == 0) ? 1 : int'(divisor);
        return 16.0 * real'(d) * CLK_NS * factor;
    endfunction

    task automatic send_frame(input logic [8:0] d, input int nb, input bit bad_par,
                              input bit bad_stop, input real bt);
        logic p;
        p = 1'b0;
        rxd = 1'b0;
        #(bt);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            p   = p ^ d[i];
            #(bt);
        end
        if (par_en) begin
            rxd = p ^ par_odd ^ bad_par;
            #(bt);
        end
        if (bad_stop) begin
            rxd = 1'b0;
            #(bt * 0.7);
            rxd = 1'b1;
            #(bt * 1.3);
        end else begin
            rxd = 1'b1;
            #(bt * 2.0);
        end
    endtask

    task automatic read_buf();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && data_ready && !rd_strobe) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected word", 64'(rbuf), 64'h0);
                end else begin
                    exp_t  e;
                    string t;
                    e = sb_q.pop_front();
                    t = tag_q.pop_front();
                    check({rbuf, frame_err, parity_err} == {e.word, e.fe, e.pe}, t,
                          "buffer/fe/pe", 64'({rbuf, frame_err, parity_err}), 64'(e));
                    check(overrun == 1'b0, "R9", "no overrun on prompt read",
                          64'(overrun), 64'h0);
                end
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(data_ready == 1'b0, "R7", "ready after reset", 64'(data_ready), 64'h0);
        check(rbuf == 32'h0, "R7", "buffer after reset", 64'(rbuf), 64'h0);
        check(overrun == 1'b0, "R9", "overrun after reset", 64'(overrun), 64'h0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R2: 8-bit and 9-bit, LSB first
        expect_word(32'h0000_00A5, 0, 0, "R2"); send_frame(9'h0A5, 8, 0, 0, bit_ns(1.0));
        expect_word(32'h0000_003C, 0, 0, "R2"); send_frame(9'h13C, 8, 0, 0, bit_ns(1.0));
        drain();
        nine_bit = 1'b1;
        expect_word(32'h0000_01A5, 0, 0, "R2"); send_frame(9'h1A5, 9, 0, 0, bit_ns(1.0));
        drain();

        // R6: rate error, back to back
        expect_word(32'h0000_0133, 0, 0, "R6"); send_frame(9'h133, 9, 0, 0, bit_ns(0.98));
        expect_word(32'h0000_00CE, 0, 0, "R6"); send_frame(9'h0CE, 9, 0, 0, bit_ns(1.02));
        drain();
        nine_bit = 1'b0;
        expect_word(32'h0000_005A, 0, 0, "R6"); send_frame(9'h05A, 8, 0, 0, bit_ns(0.98));
        expect_word(32'h0000_00C3, 0, 0, "R6"); send_frame(9'h0C3, 8, 0, 0, bit_ns(1.02));
        drain();

        // R5: parity
        par_en = 1'b1; par_odd = 1'b0;
        expect_word(32'h0000_005B, 0, 0, "R5"); send_frame(9'h05B, 8, 0, 0, bit_ns(1.0));
        expect_word(32'h0000_005B, 0, 1, "R5"); send_frame(9'h05B, 8, 1, 0, bit_ns(1.0));
        drain();
        par_odd = 1'b1;
        expect_word(32'h0000_0060, 0, 0, "R5"); send_frame(9'h060, 8, 0, 0, bit_ns(1.0));
        expect_word(32'h0000_0060, 0, 1, "R5"); send_frame(9'h060, 8, 1, 0, bit_ns(1.0));
        drain();
        par_en = 1'b0; par_odd = 1'b0;

        // R4: framing error, then clean frame
        expect_word(32'h0000_0077, 1, 0, "R4"); send_frame(9'h077, 8, 0, 1, bit_ns(1.0));
        expect_word(32'h0000_0081, 0, 0, "R4"); send_frame(9'h081, 8, 0, 0, bit_ns(1.0));
        drain();

        // R3: glitch shorter than half a bit
        @(negedge clk); rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        #(bit_ns(2.0));
        check(data_ready == 1'b0, "R3", "glitch rejected", 64'(data_ready), 64'h0);
        expect_word(32'h0000_00E4, 0, 0, "R3"); send_frame(9'h0E4, 8, 0, 0, bit_ns(1.0));
        drain();

        // R1: divisor zero acts as one
        divisor = '0;
        repeat (20) @(negedge clk);
        expect_word(32'h0000_0096, 0, 0, "R1"); send_frame(9'h096, 8, 0, 0, bit_ns(1.0));
        drain();
        divisor = 16'd3;
        repeat (20) @(negedge clk);
        expect_word(32'h0000_0069, 0, 0, "R1"); send_frame(9'h069, 8, 0, 0, bit_ns(1.0));
        drain();
        divisor = 16'd4;
        repeat (20) @(negedge clk);

        // R7/R9: overrun, buffer held during frame
        mon_en = 1'b0;
        send_frame(9'h011, 8, 0, 0, bit_ns(1.0));
        check(data_ready == 1'b1, "R7", "ready after first", 64'(data_ready), 64'h1);
        fork
            send_frame(9'h022, 8, 0, 0, bit_ns(1.0));
            begin
                #(bit_ns(4.5));
                check(rbuf == 32'h11, "R7", "buffer held mid-frame", 64'(rbuf), 64'h11);
            end
        join
        check(overrun == 1'b1, "R9", "overrun set", 64'(overrun), 64'h1);
        check(rbuf == 32'h22, "R9", "buffer overwritten", 64'(rbuf), 64'h22);
        read_buf();
        @(negedge clk);
        check(data_ready == 1'b0, "R8", "read clears ready", 64'(data_ready), 64'h0);
        check(overrun == 1'b0, "R9", "read clears overrun", 64'(overrun), 64'h0);

        // R10: packing, 8-bit
        pack_en = 1'b1;
        send_frame(9'h012, 8, 0, 0, bit_ns(1.0));
        check(data_ready == 1'b0, "R10", "no ready after first half", 64'(data_ready), 64'h0);
        send_frame(9'h034, 8, 0, 0, bit_ns(1.0));
        check(data_ready == 1'b1, "R10", "ready after pair", 64'(data_ready), 64'h1);
        check(rbuf == 32'h0034_0012, "R10", "packed 8-bit", 64'(rbuf), 64'h0034_0012);
        read_buf();
        mon_en = 1'b1;

        // R10: packing, 9-bit, error flags ORed
        nine_bit = 1'b1;
        expect_word(32'h01AB_0155, 0, 0, "R10");
        send_frame(9'h155, 9, 0, 0, bit_ns(1.0));
        send_frame(9'h1AB, 9, 0, 0, bit_ns(1.0));
        drain();
        expect_word(32'h00F0_010F, 1, 0, "R10");
        send_frame(9'h10F, 9, 0, 1, bit_ns(1.0));
        send_frame(9'h0F0, 9, 0, 0, bit_ns(1.0));
        drain();
        pack_en = 1'b0;

        check(sb_q.size() == 0, "R2", "scoreboard empty", 64'(sb_q.size()), 64'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule